// File: doc/BRIEF.md
# Parallel Flash Programmer Sequencer

This block steers a byte-wide, electrically erasable, many-time-programmable parallel flash through the cycles an external programmer performs. One request selects one of three jobs. The identify job reads the two identifier bytes. The erase job fires one long whole-chip erase strobe and then checks that every byte reads back as FFh. The program job writes every address once, in ascending order, with one timed strobe per byte.

The block drives the address, the data bus with its output enable, the chip-enable, the output-enable and the program strobe. It also drives two digital requests that tell board logic to switch high voltage onto the programming-supply pin and onto address line 9. Strobe widths come from the clock frequency and a length in microseconds, so they are counted in clock cycles. Program data is taken from `src_data`, which the surrounding logic must present combinationally for the address currently on `f_addr`.

Operation codes on `op`: 0 = none, 1 = identify, 2 = erase with blank check, 3 = program all bytes.

The state machine has these states:
- `S_IDLE`: waits for a request.
- `S_SETUP`: supplies ramp, `SETUP_CYC` cycles.
- `S_ID_LO` and `S_ID_HI`: identifier reads with A0 = 0 and A0 = 1.
- `S_ERASE`: the erase strobe.
- `S_PROG`: a program strobe.
- `S_GAP`: strobe high between bytes.
- `S_HOLD`: supplies held after the last strobe, `SETUP_CYC` cycles.
- `S_VERIFY`: blank-check reads.
- `S_FINISH`: completion pulse.

Every timed state leaves when its dwell timer expires. The transitions are:
- `S_IDLE` goes to `S_SETUP` on an accepted request.
- `S_SETUP` goes to `S_ID_LO`, `S_ERASE` or `S_PROG`, depending on the job.
- `S_ID_LO` goes to `S_ID_HI`, and `S_ID_HI` goes to `S_HOLD`.
- `S_ERASE` goes to `S_HOLD`.
- `S_PROG` goes to `S_GAP`.
- `S_GAP` goes back to `S_PROG` for the next address, or to `S_HOLD` after the last address.
- `S_HOLD` goes to `S_VERIFY` for an erase and to `S_FINISH` otherwise.
- `S_VERIFY` stays in `S_VERIFY` for the next address. It goes to `S_FINISH` on a mismatch or after the last address.
- `S_FINISH` goes to `S_IDLE`.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset the block is idle: `busy`=0, `done`=0, `f_ce_n`=1, `f_oe_n`=1, `f_pgm_n`=1, `vpp_hv_en`=0, `a9_hv_en`=0, `f_dq_oe`=0.
- R2: Identify (op=1) raises `a9_hv_en` and never `vpp_hv_en`. It fires no strobe. It reads with `f_addr`=0 into `id_mfr` and then with `f_addr`=1 (A0=1) into `id_dev`.
- R3: Erase (op=2) fires exactly one strobe, `f_pgm_n` low for ERASE_US×CLK_HZ/10^6 cycles. During the strobe `vpp_hv_en`=1, `a9_hv_en`=1, `f_ce_n`=0 and `f_oe_n`=1.
- R4: After the erase strobe, with both supplies off, the block reads addresses upward from 0 for `RD_CYC` cycles each and compares each with FFh. On the first mismatch it stops with `error`=1 and `err_addr` set to that address. If every byte is blank, it ends with `error`=0. A new request clears `error`.
- R5: Program (op=3) fires exactly 2^ADDR_W strobes, one per address in ascending order. Each strobe is PROG_US×CLK_HZ/10^6 cycles long, with the address stable and `f_dq_out`=`src_data`. During each strobe `vpp_hv_en`=1, `a9_hv_en`=0, `f_ce_n`=0 and `f_oe_n`=1.
- R6: The first strobe falls exactly `SETUP_CYC` cycles after `vpp_hv_en` rises. The supply stays on for at least `SETUP_CYC` cycles after the last strobe rises.
- R7: `busy` is high from the cycle after an accepted request until completion. `done` is high for exactly one cycle per job, and `busy` is low in the cycle after it.
- R8: A request with op=0, or any request while `busy` is high, is ignored.
- R9: `f_dq_oe` is high only while programming (never while `f_oe_n`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken when idle |
| op | input | 2 | Job code: 0 none, 1 identify, 2 erase+check, 3 program |
| src_data | input | 8 | Byte to program at the current `f_addr` |
| f_dq_in | input | 8 | Flash data bus, read direction |
| f_addr | output | ADDR_W | Flash address |
| f_dq_out | output | 8 | Flash data bus, write direction |
| f_dq_oe | output | 1 | Data bus drive enable |
| f_ce_n | output | 1 | Chip enable, active low |
| f_oe_n | output | 1 | Output enable, active low |
| f_pgm_n | output | 1 | Program/erase strobe, active low |
| vpp_hv_en | output | 1 | Request high voltage on the programming-supply pin |
| a9_hv_en | output | 1 | Request high voltage on address line 9 |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Blank check failed in the last job |
| err_addr | output | ADDR_W | First address that failed the blank check |
| id_mfr | output | 8 | Manufacturer identifier byte |
| id_dev | output | 8 | Device identifier byte |

## Verification
The bench builds the block with ADDR_W=4, CLK_HZ=1 MHz, PROG_US=3, ERASE_US=40, SETUP_CYC=2 and RD_CYC=2. That gives a 16-byte array, 3-cycle program strobes and a 40-cycle erase strobe. With these values every address can be programmed and compared against an arithmetic pattern. Every strobe width and supply margin can be counted cycle by cycle. Blank-check failures can be planted at the first address, a middle address, the last address and two addresses at once.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_IDENT = 2'd1,
        OP_ERASE = 2'd2,
        OP_PROG  = 2'd3
    } fop_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SETUP,
        S_ID_LO,
        S_ID_HI,
        S_ERASE,
        S_PROG,
        S_GAP,
        S_HOLD,
        S_VERIFY,
        S_FINISH
    } fstate_e;
endpackage

// File: rtl/dwell_timer.sv
module dwell_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [TW-1:0] len,
    output logic          fin
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else          cnt <= cnt + 1'b1;
    end

    assign fin = (cnt == len - 1'b1);
endmodule

// File: rtl/addr_walker.sv
module addr_walker #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [AW-1:0] addr,
    output logic          last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   addr <= '0;
        else if (clr) addr <= '0;
        else if (inc) addr <= addr + 1'b1;
    end

    assign last = &addr;
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int CLK_HZ    = 50_000_000,
    parameter int PROG_US   = 20,
    parameter int ERASE_US  = 100_000,
    parameter int SETUP_CYC = 8,
    parameter int RD_CYC    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [7:0]        src_data,
    input  logic [7:0]        f_dq_in,
    output logic [ADDR_W-1:0] f_addr,
    output logic [7:0]        f_dq_out,
    output logic              f_dq_oe,
    output logic              f_ce_n,
    output logic              f_oe_n,
    output logic              f_pgm_n,
    output logic              vpp_hv_en,
    output logic              a9_hv_en,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [ADDR_W-1:0] err_addr,
    output logic [7:0]        id_mfr,
    output logic [7:0]        id_dev
);
    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int PROG_CYC   = CYC_PER_US * PROG_US;
    localparam int ERASE_CYC  = CYC_PER_US * ERASE_US;
    localparam int TW         = $clog2(ERASE_CYC + 2);

    fstate_e           state, state_n;
    fop_e              op_q;
    logic              fin, last, accept, blank_bad, inc, tmr_clr;
    logic [TW-1:0]     len;
    logic [ADDR_W-1:0] walk_addr;
    logic              want_vpp, want_a9;

    assign accept    = (state == S_IDLE) && start && (fop_e'(op) != OP_NONE);
    assign blank_bad = (f_dq_in != 8'hFF);
    assign want_vpp  = (op_q == OP_ERASE) || (op_q == OP_PROG);
    assign want_a9   = (op_q == OP_ERASE) || (op_q == OP_IDENT);
    assign tmr_clr   = fin || (state == S_IDLE) || (state == S_FINISH);
    assign inc       = fin && (((state == S_GAP) && !last) ||
                               ((state == S_VERIFY) && !blank_bad && !last));

    dwell_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .len(len), .fin(fin)
    );

    addr_walker #(.AW(ADDR_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .clr(accept), .inc(inc),
        .addr(walk_addr), .last(last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // Job, result and identifier registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_NONE;
            error    <= 1'b0;
            err_addr <= '0;
            id_mfr   <= '0;
            id_dev   <= '0;
        end else begin
            if (accept) begin
                op_q     <= fop_e'(op);
                error    <= 1'b0;
                err_addr <= '0;
            end
            if (fin && state == S_ID_LO) id_mfr <= f_dq_in;
            if (fin && state == S_ID_HI) id_dev <= f_dq_in;
            if (fin && state == S_VERIFY && blank_bad) begin
                error    <= 1'b1;
                err_addr <= walk_addr;
            end
        end
    end

    // Next state
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:   if (accept) state_n = S_SETUP;
            S_SETUP:  if (fin) state_n = (op_q == OP_IDENT) ? S_ID_LO :
                                         (op_q == OP_ERASE) ? S_ERASE : S_PROG;
            S_ID_LO:  if (fin) state_n = S_ID_HI;
            S_ID_HI:  if (fin) state_n = S_HOLD;
            S_ERASE:  if (fin) state_n = S_HOLD;
            S_PROG:   if (fin) state_n = S_GAP;
            S_GAP:    if (fin) state_n = last ? S_HOLD : S_PROG;
            S_HOLD:   if (fin) state_n = (op_q == OP_ERASE) ? S_VERIFY : S_FINISH;
            S_VERIFY: if (fin && (blank_bad || last)) state_n = S_FINISH;
            S_FINISH: state_n = S_IDLE;
            default:  state_n = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        f_addr    = walk_addr;
        f_dq_out  = src_data;
        f_dq_oe   = 1'b0;
        f_ce_n    = 1'b1;
        f_oe_n    = 1'b1;
        f_pgm_n   = 1'b1;
        vpp_hv_en = 1'b0;
        a9_hv_en  = 1'b0;
        len       = TW'(1);
        unique case (state)
            S_IDLE, S_FINISH: ;
            S_SETUP, S_HOLD: begin
                vpp_hv_en = want_vpp;
                a9_hv_en  = want_a9;
                f_ce_n    = (op_q == OP_IDENT);
                len       = TW'(SETUP_CYC);
            end
            S_ID_LO, S_ID_HI: begin
                a9_hv_en = 1'b1;
                f_ce_n   = 1'b0;
                f_oe_n   = 1'b0;
                f_addr   = (state == S_ID_HI) ? ADDR_W'(1) : '0;
                len      = TW'(RD_CYC);
            end
            S_ERASE: begin
                vpp_hv_en = 1'b1;
                a9_hv_en  = 1'b1;
                f_ce_n    = 1'b0;
                f_pgm_n   = 1'b0;
                len       = TW'(ERASE_CYC);
            end
            S_PROG, S_GAP: begin
                vpp_hv_en = 1'b1;
                f_ce_n    = 1'b0;
                f_dq_oe   = 1'b1;
                f_pgm_n   = (state == S_GAP);
                len       = (state == S_PROG) ? TW'(PROG_CYC) : TW'(1);
            end
            S_VERIFY: begin
                f_ce_n = 1'b0;
                f_oe_n = 1'b0;
                len    = TW'(RD_CYC);
            end
            default: ;
        endcase
    end

    assign busy = (state != S_IDLE);
    assign done = (state == S_FINISH);

    // R5
    strobe_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !f_pgm_n |-> (vpp_hv_en && !f_ce_n && f_oe_n));
    // R9
    dq_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_dq_oe |-> (f_oe_n && vpp_hv_en && !a9_hv_en));
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    // R2
    a9_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a9_hv_en && !f_oe_n) |-> (!vpp_hv_en && f_pgm_n));
    // R6
    vpp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vpp_hv_en) |-> f_pgm_n);
    // R6
    vpp_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vpp_hv_en) |-> $past(f_pgm_n));
    // R4
    error_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> done);
endmodule

// File: tb/tb_flash_prog_seq.sv
module tb_flash_prog_seq;
    localparam int AW  = 4;
    localparam int N   = 1 << AW;
    localparam int SC  = 2;
    localparam int RC  = 2;
    localparam int PW  = 3;
    localparam int EW  = 40;
    localparam logic [7:0] MFR = 8'h3C;
    localparam logic [7:0] DEV = 8'h5A;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    op = 2'd0;
    logic [7:0]    src_data, f_dq_in, f_dq_out, id_mfr, id_dev;
    logic [AW-1:0] f_addr, err_addr;
    logic          f_dq_oe, f_ce_n, f_oe_n, f_pgm_n, vpp_hv_en, a9_hv_en;
    logic          busy, done, error;

    always #2 clk = ~clk;

    flash_prog_seq #(
        .ADDR_W(AW), .CLK_HZ(1_000_000), .PROG_US(3), .ERASE_US(40),
        .SETUP_CYC(SC), .RD_CYC(RC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .src_data(src_data),
        .f_dq_in(f_dq_in), .f_addr(f_addr), .f_dq_out(f_dq_out), .f_dq_oe(f_dq_oe),
        .f_ce_n(f_ce_n), .f_oe_n(f_oe_n), .f_pgm_n(f_pgm_n), .vpp_hv_en(vpp_hv_en),
        .a9_hv_en(a9_hv_en), .busy(busy), .done(done), .error(error),
        .err_addr(err_addr), .id_mfr(id_mfr), .id_dev(id_dev)
    );

    function automatic logic [7:0] pat(int a);
        return 8'(a * 29 + 3);
    endfunction

    logic [7:0]   mem [N];
    logic [N-1:0] stuck = '0;

    assign src_data = pat(int'(f_addr));
    assign f_dq_in  = (!f_ce_n && !f_oe_n) ?
                      (a9_hv_en ? (f_addr[0] ? DEV : MFR) :
                       (stuck[f_addr] ? 8'h7F : mem[f_addr])) : 8'h00;

    int checks = 0, errors = 0, cyc = 0;
    int done_cnt, pulses, erase_pulses, erase_w, bad_w, bad_order, addr_move;
    int vpp_rise, vpp_fall, first_fall, last_rise, reads, bad_bus, vpp_cycles, dq_cycles;
    int low_run;
    logic [AW-1:0] pulse_addr;
    logic pgm_prev = 1'b1, vpp_prev = 1'b0;
    bit timed_out = 1'b0;

    task automatic clear_stats();
        done_cnt = 0; pulses = 0; erase_pulses = 0; erase_w = 0; bad_w = 0;
        bad_order = 0; addr_move = 0; vpp_rise = -1; vpp_fall = -1;
        first_fall = -1; last_rise = -1; reads = 0; bad_bus = 0;
        vpp_cycles = 0; dq_cycles = 0; low_run = 0;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (f_dq_oe && !f_oe_n) bad_bus++;
        if (f_dq_oe) dq_cycles++;
        if (vpp_hv_en) vpp_cycles++;
        if (done) done_cnt++;
        if (!f_ce_n && !f_oe_n && !a9_hv_en) reads++;
        if (vpp_hv_en && !vpp_prev) vpp_rise = cyc;
        if (!vpp_hv_en && vpp_prev) vpp_fall = cyc;
        if (!f_pgm_n && pgm_prev) begin
            if (first_fall < 0) first_fall = cyc;
            low_run = 0;
            pulse_addr = f_addr;
        end
        if (!f_pgm_n) begin
            low_run++;
            if (f_addr != pulse_addr) addr_move++;
        end
        if (f_pgm_n && !pgm_prev) begin
            last_rise = cyc;
            if (a9_hv_en) begin
                erase_pulses++;
                erase_w = low_run;
                for (int i = 0; i < N; i++) mem[i] = 8'hFF;
            end else begin
                if (low_run != PW) bad_w++;
                if (int'(f_addr) != pulses) bad_order++;
                mem[f_addr] = mem[f_addr] & f_dq_out;
                pulses++;
            end
        end
        pgm_prev = f_pgm_n;
        vpp_prev = vpp_hv_en;
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
        if (cyc > 150000 && !timed_out) begin
            timed_out = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        end
    endtask

    task automatic run_op(logic [1:0] code, int poke);
        step();
        clear_stats();
        start = 1'b1; op = code;
        step();
        start = 1'b0; op = 2'd0;
        for (int k = 0; !done && !timed_out; k++) begin
            if (poke > 0 && k == poke) begin start = 1'b1; op = 2'd2; end
            else start = 1'b0;
            step();
        end
        start = 1'b0;
        step();
        step();
    endtask

    initial begin
        for (int i = 0; i < N; i++) mem[i] = 8'h00;
        clear_stats();
        #9 rst_n = 1'b1;
        step();
        // R1 reset state
        check(!busy && !done, "R1 busy/done", {busy, done}, 0);
        check(f_ce_n && f_oe_n && f_pgm_n, "R1 controls", {f_ce_n, f_oe_n, f_pgm_n}, 7);
        check(!vpp_hv_en && !a9_hv_en && !f_dq_oe, "R1 enables",
              {vpp_hv_en, a9_hv_en, f_dq_oe}, 0);

        // R8 op none ignored
        clear_stats();
        start = 1'b1; op = 2'd0;
        step();
        start = 1'b0;
        for (int k = 0; k < 8; k++) begin
            check(!busy, "R8 op none busy", busy, 0);
            step();
        end
        check(done_cnt == 0, "R8 op none done", done_cnt, 0);

        // R2 identify
        run_op(2'd1, 0);
        check(id_mfr == MFR, "R2 mfr byte", id_mfr, MFR);
        check(id_dev == DEV, "R2 dev byte", id_dev, DEV);
        check(pulses + erase_pulses == 0, "R2 no strobe", pulses + erase_pulses, 0);
        check(vpp_cycles == 0, "R2 vpp off", vpp_cycles, 0);
        check(done_cnt == 1, "R7 done once (ident)", done_cnt, 1);

        // R3 R4 R6 clean erase
        stuck = '0;
        run_op(2'd2, 0);
        check(erase_pulses == 1, "R3 erase count", erase_pulses, 1);
        check(erase_w == EW, "R3 erase width", erase_w, EW);
        check(!error, "R4 blank ok", error, 0);
        check(reads == N * RC, "R4 read cycles", reads, N * RC);
        check(first_fall - vpp_rise == SC, "R6 setup erase", first_fall - vpp_rise, SC);
        check(vpp_fall - last_rise >= SC, "R6 hold erase", vpp_fall - last_rise, SC);
        check(done_cnt == 1, "R7 done once (erase)", done_cnt, 1);

        // R5 R8 R9 program with an ignored erase request mid-run
        run_op(2'd3, 10);
        check(pulses == N, "R5 strobe count", pulses, N);
        check(bad_w == 0, "R5 strobe width", bad_w, 0);
        check(bad_order == 0, "R5 ascending order", bad_order, 0);
        check(addr_move == 0, "R5 address stable", addr_move, 0);
        for (int a = 0; a < N; a++)
            check(mem[a] == pat(a), "R5 programmed byte", mem[a], pat(a));
        check(erase_pulses == 0, "R8 busy request ignored", erase_pulses, 0);
        check(first_fall - vpp_rise == SC, "R6 setup prog", first_fall - vpp_rise, SC);
        check(vpp_fall - last_rise >= SC, "R6 hold prog", vpp_fall - last_rise, SC);
        check(bad_bus == 0, "R9 bus conflict", bad_bus, 0);
        check(dq_cycles > 0, "R9 bus driven in program", dq_cycles, 1);

        // R4 failures: two bad bytes, then last, then first
        stuck = '0; stuck[5] = 1'b1; stuck[11] = 1'b1;
        run_op(2'd2, 0);
        check(error, "R4 error flag", error, 1);
        check(err_addr == 5, "R4 first failing address", err_addr, 5);
        check(reads == 6 * RC, "R4 stop on mismatch", reads, 6 * RC);
        stuck = '0; stuck[N-1] = 1'b1;
        run_op(2'd2, 0);
        check(error && err_addr == AW'(N - 1), "R4 last address fail", err_addr, N - 1);
        stuck = '0; stuck[0] = 1'b1;
        run_op(2'd2, 0);
        check(error && err_addr == 0, "R4 first address fail", err_addr, 0);
        stuck = '0;
        run_op(2'd2, 0);
        check(!error, "R4 error cleared", error, 0);
        for (int a = 0; a < N; a++)
            check(mem[a] == 8'hFF, "R3 erased byte", mem[a], 8'hFF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule